// File: doc/BRIEF.md
# Calendar Clock with Alarm

This block keeps the time of day and the calendar: seconds, minutes, hours, weekday, day of month, month and two-digit year. Each pulse on the one-second tick input starts an update cycle. The block raises an in-progress flag for a fixed number of clock cycles, then advances the whole counter chain by one second. At the end of the cycle it emits a one-cycle completion pulse.

Software reaches the counters, three alarm bytes, a configuration byte and a status byte through a small byte-wide register port. The configuration byte sets three things: whether bytes are BCD or plain binary, whether hours use a 24-hour or a 12-hour clock with a PM flag, and whether updates are frozen so that a new time can be loaded. When an update finishes, the new time is compared against the three alarm bytes. Any alarm byte whose two top bits are both set counts as a wildcard.

Top module: `rtc_core`

## Requirements
- R1: After reset, the time reads 00:00:00 on weekday 01, day 01, month 01, year 00. All alarm bytes read 00h, the configuration byte reads 02h (BCD, 24-hour, running), and uip, upd_end and alarm are 0.
- R2: Register addresses are: 0h seconds, 1h seconds alarm, 2h minutes, 3h minutes alarm, 4h hours, 5h hours alarm, 6h weekday, 7h day, 8h month, 9h year. Address Ah reads {uip,7'b0}. Address Bh holds the configuration: bit 7 halt, bit 2 binary, bit 1 24-hour; its other bits read 0. Addresses Ch–Fh read 00h. A write is visible on rd_data from the next cycle on.
- R3: A tick sampled while no update is running makes uip high for exactly UIP_CYCLES cycles, starting at the next edge. At the edge that ends it, the time advances and upd_end is high for one cycle. A tick that arrives while uip is high is ignored.
- R4: While halt (Bh bit 7) is set, ticks start no update and the time does not change.
- R5: In BCD mode, seconds and minutes count 00h..59h with a decimal carry (09h→10h), and 59h wraps to 00h with a carry into the next field.
- R6: In binary mode (Bh bit 2 = 1), every field counts in plain binary (09h→0Ah), and seconds and minutes wrap from 3Bh to 00h.
- R7: In 24-hour mode, hours run 0..23 and wrap to 0, carrying into the weekday and day.
- R8: In 12-hour mode, the hour byte is {pm, hour 1..12}. 11 AM goes to 12 PM (92h BCD), 12 PM goes to 1 PM (81h), and 11 PM (91h) goes to 12 AM (12h) with a carry into the day.
- R9: The weekday runs 1..7 and wraps from 7 to 1 at midnight.
- R10: The day wraps to 1 after the last day of the month. April, June, September and November have 30 days. February has 29 days when the year value is divisible by 4 and 28 otherwise. All other months have 31 days. December wraps to January and increments the year, and year 99 wraps to 00.
- R11: alarm pulses together with upd_end exactly when each of the three alarm bytes either equals the new seconds, minutes or hours byte or has its bits 7:6 = 11b (wildcard).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1hz | input | 1 | One-cycle pulse, one per second |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | 4 | Register address |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data of the addressed register (combinational) |
| uip | output | 1 | Update in progress |
| upd_end | output | 1 | One-cycle pulse when an update has finished |
| alarm | output | 1 | One-cycle pulse when the new time matches the alarm |

## Verification
A tick sampled at edge T raises uip from T, and uip stays high through edge T+UIP_CYCLES. At that edge the new time, upd_end and alarm all appear together. rd_data follows addr in the same cycle, and a write shows there one edge after it is sampled. The bench's model steps at each rising edge and is compared with uip, upd_end and alarm at every falling edge. Register reads are made after each tick task has waited UIP_CYCLES+2 cycles, so the update has landed before the read.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int BYTE_W   = 8;
    localparam int SEC_LIM  = 60;
    localparam int MIN_LIM  = 60;
    localparam int HOUR_LIM = 24;
    localparam int WDAY_MAX = 7;
    localparam int MON_MAX  = 12;
    localparam int YEAR_MAX = 99;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef struct packed {
        byte_t sec;
        byte_t min;
        byte_t hour;
        byte_t wday;
        byte_t day;
        byte_t mon;
        byte_t year;
    } rtc_time_t;

    // byte in the selected encoding -> plain value
    function automatic byte_t dec(input byte_t v, input logic bin);
        return bin ? v : byte_t'(v[7:4]) * 8'd10 + byte_t'(v[3:0]);
    endfunction

    // plain value -> byte in the selected encoding
    function automatic byte_t enc(input byte_t n, input logic bin);
        return bin ? n : {4'(n / 8'd10), 4'(n % 8'd10)};
    endfunction

    function automatic byte_t hour_to24(input byte_t v, input logic bin, input logic h24);
        byte_t h;
        if (h24) return dec(v, bin);
        h = dec({1'b0, v[6:0]}, bin);
        if (h == 8'd12) h = 8'd0;
        return v[7] ? h + 8'd12 : h;
    endfunction

    function automatic byte_t hour_from24(input byte_t h, input logic bin, input logic h24);
        byte_t h12;
        byte_t e;
        if (h24) return enc(h, bin);
        h12 = (h >= 8'd12) ? h - 8'd12 : h;
        if (h12 == 8'd0) h12 = 8'd12;
        e = enc(h12, bin);
        return {h >= 8'd12, e[6:0]};
    endfunction

    function automatic byte_t month_days(input byte_t mon, input byte_t year);
        case (mon)
            8'd2:                    return (year[1:0] == 2'b00) ? 8'd29 : 8'd28;
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            default:                 return 8'd31;
        endcase
    endfunction

    function automatic logic is_wild(input byte_t a);
        return a[7:6] == 2'b11;
    endfunction

endpackage

// File: rtl/rtc_seq.sv
module rtc_seq #(
    parameter int UIP_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic halt,
    output logic busy,
    output logic step
);
    localparam int CW = $clog2(UIP_CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == '0) busy <= 1'b0;
            else           cnt  <= cnt - 1'b1;
        end else if (tick && !halt) begin
            busy <= 1'b1;
            cnt  <= CW'(UIP_CYCLES - 1);
        end
    end

    assign step = busy && (cnt == '0);

endmodule

// File: rtl/rtc_next.sv
module rtc_next
    import rtc_pkg::*;
(
    input  rtc_time_t cur,
    input  logic      bin,
    input  logic      h24,
    output rtc_time_t nxt
);
    byte_t s, m, h, wd, d, mo, y;

    always_comb begin
        s  = dec(cur.sec, bin) + 8'd1;
        m  = dec(cur.min, bin);
        h  = hour_to24(cur.hour, bin, h24);
        wd = cur.wday;
        d  = dec(cur.day, bin);
        mo = dec(cur.mon, bin);
        y  = dec(cur.year, bin);
        if (s == byte_t'(SEC_LIM)) begin
            s = 8'd0;
            m = m + 8'd1;
            if (m == byte_t'(MIN_LIM)) begin
                m = 8'd0;
                h = h + 8'd1;
                if (h == byte_t'(HOUR_LIM)) begin
                    h  = 8'd0;
                    wd = (wd >= byte_t'(WDAY_MAX)) ? 8'd1 : wd + 8'd1;
                    d  = d + 8'd1;
                    if (d > month_days(mo, y)) begin
                        d  = 8'd1;
                        mo = mo + 8'd1;
                        if (mo > byte_t'(MON_MAX)) begin
                            mo = 8'd1;
                            y  = (y >= byte_t'(YEAR_MAX)) ? 8'd0 : y + 8'd1;
                        end
                    end
                end
            end
        end
        nxt.sec  = enc(s, bin);
        nxt.min  = enc(m, bin);
        nxt.hour = hour_from24(h, bin, h24);
        nxt.wday = wd;
        nxt.day  = enc(d, bin);
        nxt.mon  = enc(mo, bin);
        nxt.year = enc(y, bin);
    end

endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm
    import rtc_pkg::*;
(
    input  rtc_time_t t,
    input  byte_t     al_sec,
    input  byte_t     al_min,
    input  byte_t     al_hour,
    output logic      hit
);
    logic [2:0] fld_ok;

    assign fld_ok[0] = is_wild(al_sec)  || (al_sec  == t.sec);
    assign fld_ok[1] = is_wild(al_min)  || (al_min  == t.min);
    assign fld_ok[2] = is_wild(al_hour) || (al_hour == t.hour);
    assign hit       = &fld_ok;

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int UIP_CYCLES = 4,
    parameter int ADDR_W     = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_1hz,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        rd_data,
    output logic              uip,
    output logic              upd_end,
    output logic              alarm
);
    rtc_time_t tm, tm_nxt;
    byte_t     al_sec, al_min, al_hour;
    logic      cfg_halt, cfg_bin, cfg_h24;
    logic      step, hit;

    rtc_seq #(.UIP_CYCLES(UIP_CYCLES)) u_seq (
        .clk(clk), .rst(rst), .tick(tick_1hz), .halt(cfg_halt),
        .busy(uip), .step(step)
    );

    rtc_next u_next (.cur(tm), .bin(cfg_bin), .h24(cfg_h24), .nxt(tm_nxt));

    rtc_alarm u_alarm (
        .t(tm_nxt), .al_sec(al_sec), .al_min(al_min), .al_hour(al_hour), .hit(hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            tm       <= '{sec: 8'h00, min: 8'h00, hour: 8'h00, wday: 8'h01,
                          day: 8'h01, mon: 8'h01, year: 8'h00};
            al_sec   <= '0;
            al_min   <= '0;
            al_hour  <= '0;
            cfg_halt <= 1'b0;
            cfg_bin  <= 1'b0;
            cfg_h24  <= 1'b1;
            upd_end  <= 1'b0;
            alarm    <= 1'b0;
        end else begin
            upd_end <= step;
            alarm   <= step && hit;
            if (step) tm <= tm_nxt;
            // a same-cycle software write wins over the advance
            if (wr_en) begin
                case (addr)
                    ADDR_W'(4'h0): tm.sec  <= wr_data;
                    ADDR_W'(4'h1): al_sec  <= wr_data;
                    ADDR_W'(4'h2): tm.min  <= wr_data;
                    ADDR_W'(4'h3): al_min  <= wr_data;
                    ADDR_W'(4'h4): tm.hour <= wr_data;
                    ADDR_W'(4'h5): al_hour <= wr_data;
                    ADDR_W'(4'h6): tm.wday <= wr_data;
                    ADDR_W'(4'h7): tm.day  <= wr_data;
                    ADDR_W'(4'h8): tm.mon  <= wr_data;
                    ADDR_W'(4'h9): tm.year <= wr_data;
                    ADDR_W'(4'hB): begin
                        cfg_halt <= wr_data[7];
                        cfg_bin  <= wr_data[2];
                        cfg_h24  <= wr_data[1];
                    end
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        case (addr)
            ADDR_W'(4'h0): rd_data = tm.sec;
            ADDR_W'(4'h1): rd_data = al_sec;
            ADDR_W'(4'h2): rd_data = tm.min;
            ADDR_W'(4'h3): rd_data = al_min;
            ADDR_W'(4'h4): rd_data = tm.hour;
            ADDR_W'(4'h5): rd_data = al_hour;
            ADDR_W'(4'h6): rd_data = tm.wday;
            ADDR_W'(4'h7): rd_data = tm.day;
            ADDR_W'(4'h8): rd_data = tm.mon;
            ADDR_W'(4'h9): rd_data = tm.year;
            ADDR_W'(4'hA): rd_data = {uip, 7'b0};
            ADDR_W'(4'hB): rd_data = {cfg_halt, 4'b0, cfg_bin, cfg_h24, 1'b0};
            default:       rd_data = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtc_chk.sv
module rtc_chk #(
    parameter int UIP_CYCLES = 4
) (
    input logic clk,
    input logic rst,
    input logic tick,
    input logic halt,
    input logic uip,
    input logic upd_end,
    input logic alarm
);
    logic [15:0] run;

    always_ff @(posedge clk) begin
        if (rst)      run <= '0;
        else if (uip) run <= run + 16'd1;
        else          run <= '0;
    end

    assert_uip_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(uip) |-> run == 16'(UIP_CYCLES));

    assert_uip_bound_R3: assert property (@(posedge clk) disable iff (rst)
        uip |-> run < 16'(UIP_CYCLES));

    assert_end_after_uip_R3: assert property (@(posedge clk) disable iff (rst)
        upd_end |-> !uip && $past(uip));

    assert_start_needs_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(uip) |-> $past(tick) && !$past(halt));

    assert_halt_blocks_R4: assert property (@(posedge clk) disable iff (rst)
        (halt && !uip) |=> !uip);

    assert_alarm_with_end_R11: assert property (@(posedge clk) disable iff (rst)
        alarm |-> upd_end);

endmodule

bind rtc_core rtc_chk #(.UIP_CYCLES(UIP_CYCLES)) u_chk (
    .clk(clk), .rst(rst), .tick(tick_1hz), .halt(cfg_halt),
    .uip(uip), .upd_end(upd_end), .alarm(alarm)
);

// File: tb/rtc_core_tb.sv
`timescale 1ns/1ps
module rtc_core_tb;
    localparam int UIP = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_1hz = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       uip, upd_end, alarm;

    integer n_chk = 0, n_fail = 0, cyc = 0, a_seen = 0;
    bit     done_flag = 0;

    always #2 clk = ~clk;

    rtc_core #(.UIP_CYCLES(UIP)) u_dut (
        .clk(clk), .rst(rst), .tick_1hz(tick_1hz), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .uip(uip), .upd_end(upd_end), .alarm(alarm)
    );

    // ---------------- behavioural reference model ----------------
    integer m_s, m_m, m_h, m_wd, m_d, m_mo, m_y, m_cnt;
    integer m_as, m_am, m_ah;
    bit     m_busy, m_done, m_alarm, m_halt, m_bin, m_h24;

    function automatic integer f_enc(input integer n, input bit b);
        return b ? n : (n / 10) * 16 + n % 10;
    endfunction
    function automatic integer f_dec(input integer v, input bit b);
        return b ? v : (v / 16) * 10 + v % 16;
    endfunction
    function automatic integer f_henc(input integer h, input bit b, input bit t24);
        integer k;
        if (t24) return f_enc(h, b);
        k = h % 12;
        if (k == 0) k = 12;
        return f_enc(k, b) + ((h >= 12) ? 128 : 0);
    endfunction
    function automatic integer f_hdec(input integer v, input bit b, input bit t24);
        integer k;
        if (t24) return f_dec(v, b);
        k = f_dec(v % 128, b) % 12;
        return k + ((v >= 128) ? 12 : 0);
    endfunction
    function automatic integer f_mlen(input integer mo, input integer y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction
    function automatic bit f_fld(input integer a, input integer v);
        return (a >= 192) || (a == v);
    endfunction

    always @(posedge clk) begin
        m_done  = 0;
        m_alarm = 0;
        if (rst) begin
            m_s = 0; m_m = 0; m_h = 0; m_wd = 1; m_d = 1; m_mo = 1; m_y = 0;
            m_as = 0; m_am = 0; m_ah = 0; m_busy = 0; m_cnt = 0;
            m_halt = 0; m_bin = 0; m_h24 = 1;
        end else begin
            if (m_busy) begin
                if (m_cnt == 0) begin
                    m_busy = 0;
                    m_s++;
                    if (m_s == 60) begin
                        m_s = 0; m_m++;
                        if (m_m == 60) begin
                            m_m = 0; m_h++;
                            if (m_h == 24) begin
                                m_h = 0;
                                m_wd = (m_wd == 7) ? 1 : m_wd + 1;
                                m_d++;
                                if (m_d > f_mlen(m_mo, m_y)) begin
                                    m_d = 1; m_mo++;
                                    if (m_mo == 13) begin m_mo = 1; m_y = (m_y + 1) % 100; end
                                end
                            end
                        end
                    end
                    m_done  = 1;
                    m_alarm = f_fld(m_as, f_enc(m_s, m_bin)) && f_fld(m_am, f_enc(m_m, m_bin))
                              && f_fld(m_ah, f_henc(m_h, m_bin, m_h24));
                end else m_cnt--;
            end else if (tick_1hz && !m_halt) begin
                m_busy = 1;
                m_cnt  = UIP - 1;
            end
            if (wr_en) begin
                case (addr)
                    4'h0: m_s  = f_dec(wr_data, m_bin);
                    4'h1: m_as = wr_data;
                    4'h2: m_m  = f_dec(wr_data, m_bin);
                    4'h3: m_am = wr_data;
                    4'h4: m_h  = f_hdec(wr_data, m_bin, m_h24);
                    4'h5: m_ah = wr_data;
                    4'h6: m_wd = wr_data;
                    4'h7: m_d  = f_dec(wr_data, m_bin);
                    4'h8: m_mo = f_dec(wr_data, m_bin);
                    4'h9: m_y  = f_dec(wr_data, m_bin);
                    4'hB: begin m_halt = wr_data[7]; m_bin = wr_data[2]; m_h24 = wr_data[1]; end
                    default: ;
                endcase
            end
        end
    end

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // every-clock comparison against the model
    always @(negedge clk) begin
        if (!rst && !done_flag) begin
            check({7'b0, uip},     {7'b0, m_busy},  "R3 uip");
            check({7'b0, upd_end}, {7'b0, m_done},  "R3 upd_end");
            check({7'b0, alarm},   {7'b0, m_alarm}, "R11 alarm");
            if (alarm) a_seen++;
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic rd_chk(input logic [3:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); addr = a; #1;
        check(rd_data, exp, tag);
    endtask

    task automatic do_tick();
        @(negedge clk); tick_1hz = 1;
        @(negedge clk); tick_1hz = 0;
        repeat (UIP + 2) @(negedge clk);
    endtask

    task automatic set_time(input logic [7:0] s, m, h, wd, d, mo, y);
        wr(4'h0, s); wr(4'h2, m); wr(4'h4, h); wr(4'h6, wd);
        wr(4'h7, d); wr(4'h8, mo); wr(4'h9, y);
    endtask

    task automatic finish_run();
        done_flag = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done_flag) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            finish_run();
        end
    end

    integer a0;

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R1 reset state
        rd_chk(4'h0, 8'h00, "R1 sec");   rd_chk(4'h2, 8'h00, "R1 min");
        rd_chk(4'h4, 8'h00, "R1 hour");  rd_chk(4'h6, 8'h01, "R1 wday");
        rd_chk(4'h7, 8'h01, "R1 day");   rd_chk(4'h8, 8'h01, "R1 mon");
        rd_chk(4'h9, 8'h00, "R1 year");  rd_chk(4'h5, 8'h00, "R1 al_hour");
        rd_chk(4'hB, 8'h02, "R1 cfg");   rd_chk(4'hA, 8'h00, "R1 status");
        // R2 register access
        wr(4'h0, 8'h34); rd_chk(4'h0, 8'h34, "R2 sec wr");
        wr(4'h5, 8'h07); rd_chk(4'h5, 8'h07, "R2 al_hour wr");
        wr(4'hC, 8'h55); rd_chk(4'hC, 8'h00, "R2 unmapped");
        wr(4'hB, 8'h7B); rd_chk(4'hB, 8'h02, "R2 cfg bits");
        // R5 R7 R9 R10 year-end in BCD 24h
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h31, 8'h12, 8'h99);
        do_tick(); rd_chk(4'h0, 8'h59, "R5 sec 58->59");
        do_tick();
        rd_chk(4'h0, 8'h00, "R5 sec wrap");  rd_chk(4'h2, 8'h00, "R5 min wrap");
        rd_chk(4'h4, 8'h00, "R7 hour wrap"); rd_chk(4'h6, 8'h01, "R9 wday wrap");
        rd_chk(4'h7, 8'h01, "R10 day wrap"); rd_chk(4'h8, 8'h01, "R10 mon wrap");
        rd_chk(4'h9, 8'h00, "R10 year wrap");
        wr(4'h0, 8'h09); do_tick(); rd_chk(4'h0, 8'h10, "R5 bcd carry");
        // R10 month lengths
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h23);
        do_tick(); rd_chk(4'h7, 8'h01, "R10 feb28 day"); rd_chk(4'h8, 8'h03, "R10 feb28 mon");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        do_tick(); rd_chk(4'h7, 8'h29, "R10 leap day"); rd_chk(4'h8, 8'h02, "R10 leap mon");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h29, 8'h02, 8'h24);
        do_tick(); rd_chk(4'h7, 8'h01, "R10 feb29 day"); rd_chk(4'h8, 8'h03, "R10 feb29 mon");
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h30, 8'h04, 8'h21);
        do_tick(); rd_chk(4'h7, 8'h01, "R10 apr30 day"); rd_chk(4'h8, 8'h05, "R10 apr30 mon");
        // R6 binary mode
        wr(4'hB, 8'h06);
        set_time(8'h3B, 8'h3B, 8'h17, 8'h07, 8'h1F, 8'h0C, 8'h63);
        do_tick();
        rd_chk(4'h0, 8'h00, "R6 sec wrap"); rd_chk(4'h2, 8'h00, "R6 min wrap");
        rd_chk(4'h4, 8'h00, "R6 hour wrap"); rd_chk(4'h9, 8'h00, "R6 year wrap");
        wr(4'h0, 8'h09); do_tick(); rd_chk(4'h0, 8'h0A, "R6 bin step");
        // R8 12-hour BCD
        wr(4'hB, 8'h00);
        set_time(8'h59, 8'h59, 8'h11, 8'h02, 8'h10, 8'h06, 8'h30);
        do_tick(); rd_chk(4'h4, 8'h92, "R8 11am->12pm"); rd_chk(4'h7, 8'h10, "R8 noon no carry");
        wr(4'h0, 8'h59); wr(4'h2, 8'h59);
        do_tick(); rd_chk(4'h4, 8'h81, "R8 12pm->1pm");
        set_time(8'h59, 8'h59, 8'h91, 8'h02, 8'h10, 8'h06, 8'h30);
        do_tick(); rd_chk(4'h4, 8'h12, "R8 11pm->12am");
        rd_chk(4'h6, 8'h03, "R8 wday carry"); rd_chk(4'h7, 8'h11, "R8 day carry");
        // R11 alarm
        wr(4'hB, 8'h02);
        wr(4'h1, 8'h05); wr(4'h3, 8'h30); wr(4'h5, 8'h10);
        set_time(8'h04, 8'h30, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
        a0 = a_seen; do_tick(); check(8'(a_seen - a0), 8'd1, "R11 exact match");
        a0 = a_seen; do_tick(); check(8'(a_seen - a0), 8'd0, "R11 no match");
        wr(4'h1, 8'h10); wr(4'h3, 8'hC0); wr(4'h5, 8'hFF);
        set_time(8'h09, 8'h12, 8'h09, 8'h01, 8'h01, 8'h01, 8'h00);
        a0 = a_seen; do_tick(); check(8'(a_seen - a0), 8'd1, "R11 wildcard");
        // R4 halt
        wr(4'hB, 8'h82);
        do_tick(); rd_chk(4'h0, 8'h10, "R4 halted sec"); rd_chk(4'hA, 8'h00, "R4 no uip");
        wr(4'hB, 8'h02);
        // R3 tick while busy ignored, status bit visible
        @(negedge clk); tick_1hz = 1;
        @(negedge clk); tick_1hz = 0; addr = 4'hA; #1;
        check(rd_data, 8'h80, "R2 status uip");
        @(negedge clk); tick_1hz = 1;
        @(negedge clk); tick_1hz = 0;
        repeat (UIP + 2) @(negedge clk);
        rd_chk(4'h0, 8'h11, "R3 busy tick ignored");
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule